// File: doc/BRIEF.md
# Next-PC Selector with Branch Condition Evaluation

This block works out where a 32-bit, word-addressed processor fetches next. Each cycle it takes the current program counter, the 6-bit opcode of the instruction being executed, the values of the destination-field register and of the first source register, a 16-bit immediate, a 26-bit immediate and the word at the top of the return stack. It decides whether a conditional branch is taken and selects one of four targets: the sequential address, the PC-relative branch target, the in-region jump target or the return address taken from the stack.

A branch decision comes from one subtraction, destination-field value minus source value. The zero, sign and overflow flags of that difference cover equality, inequality and the signed greater-than and less-than tests. The result goes into a register. The control sequencer can therefore sample the chosen address and a redirect flag one clock after it presents an instruction, which fits the execute step of a multicycle machine.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` is 0 and `redirect` is 0 from the next rising edge on.
- R2: Opcode 6'b001000 (branch-if-greater) is taken exactly when `rd_val` is greater than `rs1_val` as signed two's-complement numbers, including operand pairs whose difference overflows.
- R3: Opcode 6'b001001 (branch-if-less) is taken exactly when `rd_val` is less than `rs1_val` as signed numbers, including operand pairs whose difference overflows.
- R4: Opcode 6'b001010 is taken when `rd_val` equals `rs1_val`. Opcode 6'b001011 is taken when they differ.
- R5: For a taken branch, `next_pc` is `cur_pc` plus `imm16` sign-extended from bit 15, modulo 2^32, and `redirect` is 1. For a branch that is not taken, `next_pc` is `cur_pc`+1 modulo 2^32 and `redirect` is 0.
- R6: Opcodes 6'b001100 (jump) and 6'b001101 (call) give `next_pc` = {`cur_pc`[31:26], `imm26`} with `redirect` 1, whatever the register operands and `imm16` are.
- R7: Opcode 6'b001110 (return) gives `next_pc` = `stack_top` with `redirect` 1.
- R8: Every other opcode gives `next_pc` = `cur_pc`+1 and `redirect` 0. The operands, both immediates and `stack_top` have no effect.
- R9: The outputs show the inputs sampled at the previous rising edge of `clk`, exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 32 | Address of the current instruction |
| opcode | input | 6 | Opcode of the current instruction |
| rd_val | input | 32 | Value of the destination-field register (left compare operand) |
| rs1_val | input | 32 | Value of the first source register (right compare operand) |
| imm16 | input | 16 | Branch offset in words, signed |
| imm26 | input | 26 | Jump word address within the current region |
| stack_top | input | 32 | Return address at the top of the stack |
| next_pc | output | 32 | Selected next program counter, registered |
| redirect | output | 1 | 1 when the flow leaves the sequential path, registered |

## Verification
A wrong overflow or sign flag would show up only on operand pairs of opposite sign near the ends of the range. With such pairs, the address one cycle later is the branch target where it should be PC+1, or the reverse. The bench drives those pairs and random operands, and compares both outputs against a behavioural model on every cycle. A selection or decoding fault therefore appears at the ports in the cycle after the opcode that exposes it. A fault in the output register or in reset shows at the first edge after the stimulus.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared opcode values and widths for the next-PC unit.
// Assumes a 6-bit opcode field. Only the opcodes listed here change the flow.
package npc_pkg;
    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OPC_BGT  = 6'b001000;
    localparam logic [OP_W-1:0] OPC_BLT  = 6'b001001;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'b001010;
    localparam logic [OP_W-1:0] OPC_BNE  = 6'b001011;
    localparam logic [OP_W-1:0] OPC_JMP  = 6'b001100;
    localparam logic [OP_W-1:0] OPC_CALL = 6'b001101;
    localparam logic [OP_W-1:0] OPC_RET  = 6'b001110;

    // Kind of target chosen for the next address
    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_JUMP   = 2'd2,
        SEL_STACK  = 2'd3
    } sel_e;

    // Flags of the compare subtraction
    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } cmp_flags_t;
endpackage

// File: rtl/npc_flags.sv
// Module npc_flags
// Subtracts rhs from lhs and reports the zero, sign and overflow flags of
// the difference. Purely combinational. Operands are two's complement.
module npc_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0]         lhs,
    input  logic [W-1:0]         rhs,
    output npc_pkg::cmp_flags_t  flags
);
    logic [W-1:0] diff;

    // Difference and flags of lhs - rhs
    always_comb begin
        diff       = lhs + (~rhs) + {{(W-1){1'b0}}, 1'b1};
        flags.zero = (diff == '0);
        flags.neg  = diff[W-1];
        flags.ovf  = (lhs[W-1] != rhs[W-1]) && (diff[W-1] != lhs[W-1]);
    end
endmodule

// File: rtl/npc_cond.sv
// Module npc_cond
// Decodes the opcode into a target kind and evaluates the branch condition
// from the compare flags. Signed less-than is sign XOR overflow. Greater-than
// is neither less-than nor zero. Assumes the flags come from rd - rs1.
module npc_cond (
    input  logic [npc_pkg::OP_W-1:0] opcode,
    input  npc_pkg::cmp_flags_t      flags,
    output npc_pkg::sel_e            sel,
    output logic                     redirect
);
    import npc_pkg::*;

    logic lt, gt, taken, is_branch;

    // Signed relations from the flags
    always_comb begin
        lt = flags.neg ^ flags.ovf;
        gt = !lt && !flags.zero;
    end

    // Branch decision and target kind per opcode
    always_comb begin
        taken     = 1'b0;
        is_branch = 1'b0;
        sel       = SEL_SEQ;
        redirect  = 1'b0;
        unique case (opcode)
            OPC_BGT: begin is_branch = 1'b1; taken = gt;          end
            OPC_BLT: begin is_branch = 1'b1; taken = lt;          end
            OPC_BEQ: begin is_branch = 1'b1; taken = flags.zero;  end
            OPC_BNE: begin is_branch = 1'b1; taken = !flags.zero; end
            OPC_JMP, OPC_CALL: begin sel = SEL_JUMP;  redirect = 1'b1; end
            OPC_RET:           begin sel = SEL_STACK; redirect = 1'b1; end
            default: ;
        endcase
        if (is_branch && taken) begin
            sel      = SEL_BRANCH;
            redirect = 1'b1;
        end
    end
endmodule

// File: rtl/npc_target.sv
// Module npc_target
// Forms the four candidate addresses and picks one by the selector.
// Assumes word addressing, so the sequential step is 1. The jump target keeps
// the upper XLEN-JIMM_W bits of the PC.
module npc_target #(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIMM_W = 26
) (
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [JIMM_W-1:0] imm26,
    input  logic [XLEN-1:0]   stack_top,
    input  npc_pkg::sel_e     sel,
    output logic [XLEN-1:0]   target
);
    import npc_pkg::*;

    localparam int KEEP_W = XLEN - JIMM_W;
    localparam int EXT_W  = XLEN - IMM_W;

    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, offset;

    // Region-relative jump target; the layout depends on how many PC bits are kept
    generate
        if (KEEP_W > 0) begin : g_keep
            assign jmp_pc = {cur_pc[XLEN-1:JIMM_W], imm26};
        end else begin : g_full
            assign jmp_pc = imm26[XLEN-1:0];
        end
    endgenerate

    // Sequential and PC-relative candidates
    always_comb begin
        offset = {{EXT_W{imm16[IMM_W-1]}}, imm16};
        seq_pc = cur_pc + {{(XLEN-1){1'b0}}, 1'b1};
        br_pc  = cur_pc + offset;
    end

    // Final selection
    always_comb begin
        unique case (sel)
            SEL_BRANCH: target = br_pc;
            SEL_JUMP:   target = jmp_pc;
            SEL_STACK:  target = stack_top;
            default:    target = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
// Module npc_unit
// Top of the next-PC unit. Compares rd_val against rs1_val through one
// subtraction, decodes the opcode, selects the next address and registers it
// with a redirect flag. Latency is one clock. Reset is synchronous, active low.
module npc_unit #(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIMM_W = 26
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [XLEN-1:0]           cur_pc,
    input  logic [npc_pkg::OP_W-1:0]  opcode,
    input  logic [XLEN-1:0]           rd_val,
    input  logic [XLEN-1:0]           rs1_val,
    input  logic [IMM_W-1:0]          imm16,
    input  logic [JIMM_W-1:0]         imm26,
    input  logic [XLEN-1:0]           stack_top,
    output logic [XLEN-1:0]           next_pc,
    output logic                      redirect
);
    import npc_pkg::*;

    cmp_flags_t      flags;
    sel_e            sel;
    logic            redir_c;
    logic [XLEN-1:0] target_c;

    npc_flags #(.W(XLEN)) u_flags (
        .lhs   (rd_val),
        .rhs   (rs1_val),
        .flags (flags)
    );

    npc_cond u_cond (
        .opcode   (opcode),
        .flags    (flags),
        .sel      (sel),
        .redirect (redir_c)
    );

    npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JIMM_W(JIMM_W)) u_target (
        .cur_pc    (cur_pc),
        .imm16     (imm16),
        .imm26     (imm26),
        .stack_top (stack_top),
        .sel       (sel),
        .target    (target_c)
    );

    // Output register holding the chosen address and redirect flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc  <= '0;
            redirect <= 1'b0;
        end else begin
            next_pc  <= target_c;
            redirect <= redir_c;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
// Module npc_unit_chk
// Property checks on the ports of npc_unit, bound to every instance of it.
// Assumes the default 32/16/26 widths.
module npc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cur_pc,
    input logic [5:0]  opcode,
    input logic [31:0] rd_val,
    input logic [31:0] rs1_val,
    input logic [15:0] imm16,
    input logic [25:0] imm26,
    input logic [31:0] stack_top,
    input logic [31:0] next_pc,
    input logic        redirect
);
    import npc_pkg::*;

    logic is_br, is_flow;
    assign is_br   = (opcode == OPC_BGT) || (opcode == OPC_BLT) ||
                     (opcode == OPC_BEQ) || (opcode == OPC_BNE);
    assign is_flow = is_br || (opcode == OPC_JMP) || (opcode == OPC_CALL) ||
                     (opcode == OPC_RET);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (next_pc == 32'd0 && !redirect));

    // R4
    beq_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BEQ && rd_val == rs1_val) |=> redirect);

    // R5
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_br |=> (next_pc == (redirect ? $past(cur_pc) + {{16{$past(imm16[15])}}, $past(imm16)}
                                        : $past(cur_pc) + 32'd1)));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_JMP || opcode == OPC_CALL) |=>
        (redirect && next_pc == {$past(cur_pc[31:26]), $past(imm26)}));

    // R7
    return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_RET) |=> (redirect && next_pc == $past(stack_top)));

    // R8
    sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_flow |=> (!redirect && next_pc == $past(cur_pc) + 32'd1));
endmodule

bind npc_unit npc_unit_chk u_npc_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_pc    (cur_pc),
    .opcode    (opcode),
    .rd_val    (rd_val),
    .rs1_val   (rs1_val),
    .imm16     (imm16),
    .imm26     (imm26),
    .stack_top (stack_top),
    .next_pc   (next_pc),
    .redirect  (redirect)
);

// File: tb/npc_unit_bench.sv
// Bench for npc_unit: a behavioural model gives the expected outputs for each
// applied vector, and the bench compares them one clock later on every cycle.
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [5:0]  opcode = '0;
    logic [31:0] rd_val = '0;
    logic [31:0] rs1_val = '0;
    logic [15:0] imm16 = '0;
    logic [25:0] imm26 = '0;
    logic [31:0] stack_top = '0;
    logic [31:0] next_pc;
    logic        redirect;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    bit          have_exp = 0;
    logic [31:0] exp_pc;
    logic        exp_red;
    string       exp_tag;

    always #10 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .opcode(opcode),
        .rd_val(rd_val), .rs1_val(rs1_val), .imm16(imm16), .imm26(imm26),
        .stack_top(stack_top), .next_pc(next_pc), .redirect(redirect)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Behavioural reference model
    task automatic model(input logic [5:0] op, input logic [31:0] pc, a, b,
                         input logic [15:0] i16, input logic [25:0] i26,
                         input logic [31:0] st, output logic [31:0] np,
                         output logic red);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint off = longint'($signed(i16));
        bit tk;
        np = pc + 32'd1; red = 0;
        if (op >= 6'd8 && op <= 6'd11) begin
            case (op)
                6'd8:    tk = sa > sb;
                6'd9:    tk = sa < sb;
                6'd10:   tk = sa == sb;
                default: tk = sa != sb;
            endcase
            if (tk) begin
                np = 32'(longint'(pc) + off);
                red = 1;
            end
        end else if (op == 6'd12 || op == 6'd13) begin
            np = {pc[31:26], i26}; red = 1;
        end else if (op == 6'd14) begin
            np = st; red = 1;
        end
    endtask

    task automatic compare_prev();
        if (have_exp) begin
            total++;
            if (next_pc !== exp_pc || redirect !== exp_red) begin
                bad++;
                $display("FAIL %s: actual pc=%h red=%b expected pc=%h red=%b",
                         exp_tag, next_pc, redirect, exp_pc, exp_red);
            end
        end
    endtask

    // Check the outputs for the previous vector, then apply a new one
    task automatic apply(input string tag, input logic [5:0] op,
                         input logic [31:0] pc, a, b, input logic [15:0] i16,
                         input logic [25:0] i26, input logic [31:0] st);
        @(negedge clk);
        compare_prev();
        opcode = op; cur_pc = pc; rd_val = a; rs1_val = b;
        imm16 = i16; imm26 = i26; stack_top = st;
        model(op, pc, a, b, i16, i26, st, exp_pc, exp_red);
        exp_tag = tag;
        have_exp = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare_prev();
        have_exp = 0;
        rst_n = 0;
        opcode = 6'd12; imm26 = 26'h3FFFFFF;
        repeat (2) @(negedge clk);
        total++;
        if (next_pc !== 32'd0 || redirect !== 1'b0) begin
            bad++;
            $display("FAIL R1: actual pc=%h red=%b expected pc=00000000 red=0",
                     next_pc, redirect);
        end
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        // R2: signed greater-than, including overflowing differences
        apply("R2", 6'd8, 32'h100, 32'd5, 32'hFFFFFFFD, 16'h0010, 26'h0, 32'h0);
        apply("R2", 6'd8, 32'h100, 32'd7, 32'd7, 16'h0010, 26'h0, 32'h0);
        apply("R2", 6'd8, 32'h200, 32'h7FFFFFFF, 32'h80000000, 16'hFFF0, 26'h0, 32'h0);
        apply("R2", 6'd8, 32'h200, 32'h80000000, 32'h7FFFFFFF, 16'hFFF0, 26'h0, 32'h0);
        // R3: signed less-than
        apply("R3", 6'd9, 32'h300, 32'h80000000, 32'h7FFFFFFF, 16'h0004, 26'h0, 32'h0);
        apply("R3", 6'd9, 32'h300, 32'h7FFFFFFF, 32'h80000000, 16'h0004, 26'h0, 32'h0);
        apply("R3", 6'd9, 32'h300, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0004, 26'h0, 32'h0);
        apply("R3", 6'd9, 32'h300, 32'hFFFFFFFE, 32'hFFFFFFFF, 16'h0004, 26'h0, 32'h0);
        // R4: equality and inequality
        apply("R4", 6'd10, 32'h40, 32'hDEADBEEF, 32'hDEADBEEF, 16'h0002, 26'h0, 32'h0);
        apply("R4", 6'd10, 32'h40, 32'hDEADBEEF, 32'hDEADBEEE, 16'h0002, 26'h0, 32'h0);
        apply("R4", 6'd11, 32'h40, 32'h1, 32'h0, 16'h0002, 26'h0, 32'h0);
        apply("R4", 6'd11, 32'h40, 32'h0, 32'h0, 16'h0002, 26'h0, 32'h0);
        // R5: target wrap in both directions
        apply("R5", 6'd10, 32'h0, 32'h0, 32'h0, 16'hFFFF, 26'h0, 32'h0);
        apply("R5", 6'd11, 32'hFFFFFFFF, 32'h0, 32'h0, 16'h8000, 26'h0, 32'h0);
        apply("R5", 6'd10, 32'hFFFFFFF0, 32'h1, 32'h1, 16'h7FFF, 26'h0, 32'h0);
        // R6: jump and call keep upper PC bits, ignore operands
        apply("R6", 6'd12, 32'hFC000123, 32'h5, 32'h9, 16'h1234, 26'h0000155, 32'h0);
        apply("R6", 6'd13, 32'h0BFFFFFF, 32'h0, 32'h0, 16'hFFFF, 26'h3FFFFFF, 32'h11);
        // R7: return
        apply("R7", 6'd14, 32'h500, 32'h3, 32'h3, 16'h0001, 26'h1, 32'hCAFEF00D);
        // R8: other opcodes step by one
        apply("R8", 6'd0, 32'h10, 32'h1, 32'h1, 16'h0100, 26'h100, 32'h99);
        apply("R8", 6'd5, 32'hFFFFFFFF, 32'h2, 32'h1, 16'hFFFF, 26'h3FFFFFF, 32'h99);
        apply("R8", 6'd15, 32'h77, 32'h0, 32'h0, 16'h0000, 26'h0, 32'h1234);
        apply("R8", 6'd63, 32'h88, 32'h9, 32'h9, 16'h0005, 26'h5, 32'h5);
        // R9: back-to-back vectors, each checked exactly one cycle later
        for (int i = 0; i < 400; i++) begin
            logic [5:0] op;
            op = (i % 3 == 0) ? 6'($urandom_range(0, 63)) : 6'($urandom_range(8, 14));
            apply("R9", op, $urandom, (i % 5 == 0) ? 32'h1234 : $urandom,
                  (i % 5 == 0) ? 32'h1234 : $urandom, 16'($urandom),
                  26'($urandom), $urandom);
        end
        do_reset();
        apply("R9", 6'd14, 32'h0, 32'h0, 32'h0, 16'h0, 26'h0, 32'hA5A5A5A5);
        apply("R9", 6'd1, 32'h7, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0);
        @(negedge clk);
        compare_prev();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule